// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Front End

This block is the control side of a single-ported synchronous SRAM with one shared data bus. The word is 32 bits wide and has four byte lanes. The array depth is set by a parameter. Each rising clock edge samples three chip selects, two competing address strobes, a burst-advance input and the write-qualifying inputs. From these the block decides whether the cycle starts an access, continues a burst or does nothing. A started access loads the address register and the two-bit burst counter. Each continued access takes the next address in either linear or interleaved order.

A write drives per-lane write enables into the array in the same cycle. A read presents the addressed word one edge later. The data bus is split into an input word, an output word and a drive-enable for the pad. The output-enable pin gates the drive-enable with no clock in the path. Any write that is decoded turns the drive off, whatever the output-enable pin does. An asynchronous sleep request passes through a two-flop synchronizer and a counted entry and recovery window. During sleep the contents are kept. Any access in progress is dropped, and any strobe seen while the block is blocked is recorded in a sticky error flag.

None of the interfaces is a stream, so there is no valid/ready handshake and no back-pressure. Every pin is plain control or data, sampled or driven on each clock.

Top module: `sbsram_front`

## Requirements
- R1: A write starts at a rising edge only when `cs0_n`=0, `cs1`=1, `cs2_n`=0, `strobe_c_n`=0, `strobe_p_n`=1 and the write inputs call for a write. The data on `dq_in` is then stored at `addr` in that same edge.
- R2: When `strobe_p_n`=0 with the chip selected, `strobe_c_n` is ignored. The cycle starts a read of `addr`, and no lane is written even if the write inputs are active.
- R3: Write decode works as follows. If `wr_all_n`=0, all four lanes are written. Otherwise, if `wr_en_n`=0, only the lanes whose `lane_wr_n` bit is 0 are written. Bit 0 is `dq[7:0]`, bit 1 is `dq[15:8]`, bit 2 is `dq[23:16]` and bit 3 is `dq[31:24]`. If neither condition holds, or no lane is selected, the cycle is a read. `lane_we` shows the lanes being written, combinationally, in the cycle before the writing edge.
- R4: After a read edge, `dq_out` holds the addressed word and `dq_drive`=1. This lasts while `oe_n`=0 and no write is decoded, until the next edge that is not a read.
- R5: In any cycle where a write is decoded, `dq_drive`=0, even when `oe_n`=0.
- R6: `oe_n`=1 forces `dq_drive`=0 in the same cycle, with no clock edge between them.
- R7: A start loads the address register and the burst base `addr[1:0]`. Each later edge with `adv_n`=0 and both strobes high accesses the next burst address, either reading or writing as R3 decides. For burst step k, with k from 1 to 3 and wrapping after that, the low two address bits are `(base+k) mod 4` when `burst_interleave`=0 and `base XOR k` when `burst_interleave`=1. The upper address bits stay at their captured value.
- R8: A strobe sampled while the chip is not selected ends the burst. It writes nothing, and `adv_n` has no effect until the next start.
- R9: `asleep` rises at the fifth rising edge after `sleep_req` is first sampled high. Strobes are blocked from the fourth such edge. After release, `asleep` falls at the third edge and strobes are accepted again from the sixth. Stored words are kept across sleep.
- R10: Once blocking begins, any burst or pending read is dropped: `dq_drive` goes to 0 and `adv_n` does nothing.
- R11: A strobe that is low at an edge while blocked is ignored and sets `proto_err`. Only reset clears `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| strobe_p_n | input | 1 | Processor-side address strobe, active low, has priority |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_interleave | input | 1 | 1 = interleaved burst order, 0 = linear |
| addr | input | AW | Word address (AW = log2 DEPTH, 6 by default) |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_en_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data to the bus |
| dq_drive | output | 1 | Bus driver enable |
| lane_we | output | 4 | Per-lane array write enables |
| asleep | output | 1 | Sleep reached |
| proto_err | output | 1 | Sticky strobe-while-blocked flag |

## Verification
The hardest situation to reach is a burst, or a pending read, that is still running when the synchronized sleep request starts blocking. While the block is blocked a strobe arrives, and after wake-up the words written before sleep must still read back. The directed part of the stimulus starts a read burst and holds `adv_n` low while `sleep_req` rises. It then drives one strobe inside the blocked window, releases the request and reads back after recovery. A random phase then mixes selects, strobes, lane patterns and sleep pulses. On every clock it is compared with a behavioural model.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    SLP_AWAKE  = 2'd0,
    SLP_ENTER  = 2'd1,
    SLP_ASLEEP = 2'd2,
    SLP_WAKE   = 2'd3
  } slp_state_e;

  // low address bits for burst step 'off' from base 'base'
  function automatic logic [1:0] burst_seq(input logic [1:0] base,
                                           input logic [1:0] off,
                                           input logic       interleave);
    return interleave ? (base ^ off) : (base + off);
  endfunction
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             strobe_p_n,
  input  logic             strobe_c_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             blocked,
  input  logic             burst_act,
  output logic             start_o,
  output logic             cont_o,
  output logic             desel_o,
  output logic             rd_o,
  output logic [LANES-1:0] lane_we_o
);
  logic             sel, p_low, c_low, p_take, c_take, wr;
  logic [LANES-1:0] req_lanes;

  assign sel    = ~cs0_n & cs1 & ~cs2_n;
  assign p_low  = ~strobe_p_n;
  assign c_low  = ~strobe_c_n;
  assign p_take = p_low & sel & ~blocked;
  assign c_take = ~p_low & c_low & sel & ~blocked;

  always_comb begin
    if (!wr_all_n)     req_lanes = '1;
    else if (!wr_en_n) req_lanes = ~lane_wr_n;
    else               req_lanes = '0;
  end

  assign cont_o    = ~blocked & ~p_low & ~c_low & ~adv_n & burst_act;
  assign start_o   = p_take | c_take;
  assign desel_o   = (p_low | c_low) & ~sel;
  assign wr        = (c_take | cont_o) & (|req_lanes);
  assign lane_we_o = wr ? req_lanes : '0;
  assign rd_o      = (start_o | cont_o) & ~wr;

  // R2: a processor-strobe start never writes
  a_r2_p_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (p_low && sel && !blocked) |-> (lane_we_o == '0));
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic       kill,
  input  logic [1:0] base,
  input  logic       interleave,
  output logic [1:0] low_o,
  output logic       active_o
);
  logic [1:0] base_q, off_q, cur_off, cur_base;
  logic       act_q;

  always_comb begin
    cur_off  = load ? 2'd0 : off_q + 2'd1;
    cur_base = load ? base : base_q;
    low_o    = burst_seq(cur_base, cur_off, interleave);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      act_q  <= 1'b1;
      base_q <= base;
      off_q  <= '0;
    end else begin
      if (step) off_q <= off_q + 2'd1;
      if (kill) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sbsram_sleep.sv
module sbsram_sleep
  import sbsram_pkg::*;
#(
  parameter int SLEEP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic strobe_any,
  output logic blocked_o,
  output logic asleep_o,
  output logic err_o
);
  localparam int CW = (SLEEP_CYC > 1) ? $clog2(SLEEP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLEEP_CYC - 1);

  logic          s1, s2, err_q;
  logic [CW-1:0] cnt;
  slp_state_e    st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= sleep_req;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SLP_AWAKE;
      cnt <= '0;
    end else begin
      unique case (st)
        SLP_AWAKE: if (s2) begin st <= SLP_ENTER; cnt <= '0; end
        SLP_ENTER: begin
          if (!s2)              begin st <= SLP_WAKE; cnt <= '0; end
          else if (cnt == LAST) st <= SLP_ASLEEP;
          else                  cnt <= cnt + 1'b1;
        end
        SLP_ASLEEP: if (!s2) begin st <= SLP_WAKE; cnt <= '0; end
        SLP_WAKE: begin
          if (s2)               begin st <= SLP_ENTER; cnt <= '0; end
          else if (cnt == LAST) st <= SLP_AWAKE;
          else                  cnt <= cnt + 1'b1;
        end
        default: st <= SLP_AWAKE;
      endcase
    end
  end

  assign blocked_o = (st != SLP_AWAKE);
  assign asleep_o  = (st == SLP_ASLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (blocked_o && strobe_any) err_q <= 1'b1;
  end
  assign err_o = err_q;

  // R11: error flag is sticky until reset
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R9: sleep is only reached while the synchronized request is high
  a_r9_sync_before_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(s2));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem_l [DEPTH];
    logic [BYTE_W-1:0] rd_l;
    always_ff @(posedge clk) begin
      if (we[g]) mem_l[addr] <= wdata[g*BYTE_W +: BYTE_W];
      if (re)    rd_l        <= mem_l[addr];
    end
    assign rdata[g*BYTE_W +: BYTE_W] = rd_l;
  end
endmodule

// File: rtl/sbsram_front.sv
module sbsram_front
  import sbsram_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SLEEP_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs0_n,
  input  logic                     cs1,
  input  logic                     cs2_n,
  input  logic                     strobe_p_n,
  input  logic                     strobe_c_n,
  input  logic                     adv_n,
  input  logic                     burst_interleave,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic                     wr_all_n,
  input  logic                     wr_en_n,
  input  logic [3:0]               lane_wr_n,
  input  logic                     oe_n,
  input  logic                     sleep_req,
  input  logic [31:0]              dq_in,
  output logic [31:0]              dq_out,
  output logic                     dq_drive,
  output logic [3:0]               lane_we,
  output logic                     asleep,
  output logic                     proto_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = AW - 2;

  logic          blocked, start, cont, desel, rd, burst_act, rd_valid_q;
  logic [1:0]    low;
  logic [HW-1:0] ahi_q;
  logic [AW-1:0] eff_addr;

  sbsram_sleep #(.SLEEP_CYC(SLEEP_CYC)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .strobe_any(~strobe_p_n | ~strobe_c_n),
    .blocked_o (blocked),
    .asleep_o  (asleep),
    .err_o     (proto_err)
  );

  sbsram_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs0_n     (cs0_n),
    .cs1       (cs1),
    .cs2_n     (cs2_n),
    .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n),
    .adv_n     (adv_n),
    .wr_all_n  (wr_all_n),
    .wr_en_n   (wr_en_n),
    .lane_wr_n (lane_wr_n),
    .blocked   (blocked),
    .burst_act (burst_act),
    .start_o   (start),
    .cont_o    (cont),
    .desel_o   (desel),
    .rd_o      (rd),
    .lane_we_o (lane_we)
  );

  sbsram_burst u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .step      (cont),
    .kill      (desel | blocked),
    .base      (addr[1:0]),
    .interleave(burst_interleave),
    .low_o     (low),
    .active_o  (burst_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahi_q      <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (start) ahi_q <= addr[AW-1:2];
      rd_valid_q <= rd;
    end
  end

  assign eff_addr = {(start ? addr[AW-1:2] : ahi_q), low};

  sbsram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk  (clk),
    .we   (lane_we),
    .re   (rd),
    .addr (eff_addr),
    .wdata(dq_in),
    .rdata(dq_out)
  );

  assign dq_drive = ~oe_n & rd_valid_q & ~(|lane_we);

  // R10: blocking drops any pending read on the next edge
  a_r10_valid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !rd_valid_q);
  // R9: nothing is written while asleep
  a_r9_no_write_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (lane_we == '0));
endmodule

// File: tb/sbsram_front_tb.sv
module sbsram_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs0_n, cs1, cs2_n, strobe_p_n, strobe_c_n, adv_n, burst_interleave;
  logic [5:0]  addr;
  logic        wr_all_n, wr_en_n, oe_n, sleep_req;
  logic [3:0]  lane_wr_n;
  logic [31:0] dq_in;
  logic [31:0] dq_out;
  logic        dq_drive, asleep, proto_err;
  logic [3:0]  lane_we;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int          m_st = 0, m_cnt = 0;
  bit          m_s1 = 0, m_s2 = 0, m_act = 0, m_rdv = 0, m_err = 0;
  int          m_base = 0, m_off = 0, m_ahi = 0;
  logic [31:0] m_rdd = '0;
  logic [3:0]  m_rdk = '0;
  logic [31:0] mem  [64];
  logic [3:0]  memk [64];

  always #4 clk = ~clk;

  sbsram_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .burst_interleave(burst_interleave), .addr(addr), .wr_all_n(wr_all_n),
    .wr_en_n(wr_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n), .sleep_req(sleep_req),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive), .lane_we(lane_we),
    .asleep(asleep), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input string ctx,
                     input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (ctx %s) %s got %h exp %h", req, ctx, what, got, exp);
    end
  endtask

  task automatic idle();
    cs0_n = 0; cs1 = 1; cs2_n = 0; strobe_p_n = 1; strobe_c_n = 1; adv_n = 1;
    wr_all_n = 1; wr_en_n = 1; lane_wr_n = 4'hF; oe_n = 0; addr = '0; dq_in = '0;
  endtask

  // one clock: check combinational outputs, then advance the model at the edge
  task automatic step(input string ctx);
    bit blk, sel, pt, ct, ds, cn, st, wr, rd, ed;
    logic [3:0] rq, ew;
    logic [31:0] msk;
    int a, lo, off;
    #2;
    blk = (m_st != 0);
    sel = !cs0_n && cs1 && !cs2_n;
    pt  = !strobe_p_n && sel && !blk;
    ct  = strobe_p_n && !strobe_c_n && sel && !blk;
    ds  = (!strobe_p_n || !strobe_c_n) && !sel;
    cn  = !blk && strobe_p_n && strobe_c_n && !adv_n && m_act;
    st  = pt || ct;
    if (!wr_all_n) rq = 4'hF;
    else if (!wr_en_n) rq = ~lane_wr_n;
    else rq = 4'h0;
    wr = (ct || cn) && (rq != 0);
    rd = (st || cn) && !wr;
    ew = wr ? rq : 4'h0;
    ed = !oe_n && m_rdv && (ew == 0);
    chk(lane_we == ew, "R3", ctx, "lane_we", 32'(lane_we), 32'(ew));
    chk(dq_drive == ed, wr ? "R5" : (oe_n ? "R6" : "R4"), ctx, "dq_drive",
        32'(dq_drive), 32'(ed));
    if (ed) begin
      for (int l = 0; l < 4; l++) msk[l*8 +: 8] = m_rdk[l] ? 8'hFF : 8'h00;
      chk(((dq_out ^ m_rdd) & msk) == 0, "R4", ctx, "dq_out", dq_out, m_rdd);
    end
    chk(asleep == (m_st == 2), "R9", ctx, "asleep", 32'(asleep), 32'(m_st == 2));
    chk(proto_err == m_err, "R11", ctx, "proto_err", 32'(proto_err), 32'(m_err));
    @(posedge clk);
    // address of this access
    if (st) a = int'(addr);
    else begin
      off = (m_off + 1) % 4;
      lo  = burst_interleave ? (m_base ^ off) : ((m_base + off) % 4);
      a   = m_ahi * 4 + lo;
    end
    if (wr) begin
      for (int l = 0; l < 4; l++)
        if (ew[l]) begin
          mem[a][l*8 +: 8] = dq_in[l*8 +: 8];
          memk[a][l] = 1'b1;
        end
    end
    if (rd) begin
      m_rdd = mem[a];
      m_rdk = memk[a];
    end
    m_rdv = rd;
    if (st) begin
      m_act = 1; m_base = int'(addr) % 4; m_off = 0; m_ahi = int'(addr) / 4;
    end else begin
      if (cn) m_off = (m_off + 1) % 4;
      if (ds || blk) m_act = 0;
    end
    if (blk && (!strobe_p_n || !strobe_c_n)) m_err = 1;
    case (m_st)
      0: if (m_s2) begin m_st = 1; m_cnt = 0; end
      1: if (!m_s2) begin m_st = 3; m_cnt = 0; end
         else if (m_cnt == 1) m_st = 2;
         else m_cnt++;
      2: if (!m_s2) begin m_st = 3; m_cnt = 0; end
      default: if (m_s2) begin m_st = 1; m_cnt = 0; end
               else if (m_cnt == 1) m_st = 0;
               else m_cnt++;
    endcase
    m_s2 = m_s1;
    m_s1 = sleep_req;
    #1;
  endtask

  task automatic cwrite(input int a, input logic [31:0] d, input logic [3:0] lanes,
                        input bit all);
    idle(); strobe_c_n = 0; addr = 6'(a); dq_in = d;
    if (all) wr_all_n = 0;
    else begin wr_en_n = 0; lane_wr_n = ~lanes; end
  endtask

  task automatic pread(input int a);
    idle(); strobe_p_n = 0; addr = 6'(a);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; memk[i] = '0; end
    idle(); burst_interleave = 0; sleep_req = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(); step("R4");                                  // reset state
    cwrite(5, 32'hA5A5_0001, 4'h0, 1); step("R1");
    cwrite(6, 32'h1122_3344, 4'h0, 1); step("R1");
    cwrite(6, 32'hAABB_CCDD, 4'b0101, 0); step("R3");    // lanes 0 and 2
    idle(); strobe_c_n = 0; addr = 7; wr_en_n = 0; step("R3"); // no lane -> read
    pread(6); step("R2");
    idle(); step("R4");                                  // 11BB33DD expected
    pread(5); step("R4");
    idle(); oe_n = 1; step("R6");
    pread(5); step("R4");
    cwrite(12, 32'h0C0C_0C0C, 4'h0, 1); step("R5");
    cwrite(9, 32'h0000_0099, 4'h0, 1); step("R2");
    pread(9); strobe_c_n = 0; wr_all_n = 0; dq_in = 32'hDEAD_BEEF; step("R2");
    idle(); step("R2");                                  // still 0x99
    cwrite(9, 32'h5555_5555, 4'h0, 1); cs1 = 0; step("R8");
    idle(); adv_n = 0; step("R8");
    idle(); step("R8");
    pread(9); step("R1");
    idle(); step("R1");
    for (int i = 16; i < 20; i++) begin cwrite(i, 32'h1000_0000 + i, 4'h0, 1); step("R7"); end
    pread(18); step("R7");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 0; step("R7"); end
    idle(); step("R7");
    pread(17); burst_interleave = 1; step("R7");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 0; burst_interleave = 1; step("R7"); end
    burst_interleave = 0;
    cwrite(22, 32'h2200_0000, 4'h0, 1); step("R7");
    for (int k = 0; k < 3; k++) begin
      idle(); adv_n = 0; wr_all_n = 0; dq_in = 32'h2200_0001 + k; step("R7");
    end
    for (int i = 20; i < 24; i++) begin pread(i); step("R7"); end
    idle(); step("R7");
    // burst in flight while sleep begins
    pread(16); step("R10");
    sleep_req = 1;
    for (int k = 0; k < 6; k++) begin idle(); adv_n = 0; step("R10"); end
    idle(); strobe_p_n = 0; addr = 5; step("R11");
    for (int k = 0; k < 4; k++) begin idle(); step("R9"); end
    sleep_req = 0;
    for (int k = 0; k < 6; k++) begin idle(); step("R9"); end
    pread(5); step("R9");
    idle(); step("R9");
    pread(6); step("R9");
    idle(); step("R9");
    // random phase
    for (int i = 0; i < 1500; i++) begin
      idle();
      cs0_n = ($urandom % 10) == 0;
      cs1   = ($urandom % 10) != 0;
      cs2_n = ($urandom % 12) == 0;
      strobe_p_n = ($urandom % 8) != 0;
      strobe_c_n = ($urandom % 6) != 0;
      adv_n = ($urandom % 5) < 3;
      burst_interleave = $urandom % 2;
      addr = 6'($urandom);
      wr_all_n = ($urandom % 5) != 0;
      wr_en_n = $urandom % 2;
      lane_wr_n = 4'($urandom);
      oe_n = ($urandom % 5) == 0;
      dq_in = $urandom;
      if ((i % 200) == 120) sleep_req = 1;
      if ((i % 200) == 140) sleep_req = 0;
      step("R1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule